// File: doc/BRIEF.md
# Controller Port Serial Deserializer

This block gathers the inputs of two game controller ports through an external parallel-to-serial converter. It drives the converter with a serial clock, divided down from the system clock, and with a load strobe. It then shifts the converter's serial data in, one bit on each rising serial-clock edge, and assembles a 16-bit frame. Frames repeat without a break, so the port state is refreshed once every frame period.

Eight bits of each frame are the quadrature lines of the two ports, four per port. The counter block that follows reads them. The other eight bits are miscellaneous control inputs. They appear as the upper byte of an identification word, whose lower byte is a fixed parameter. All outputs change together, in one system cycle, after the last bit of a frame has arrived. A one-cycle tick marks that update.

The control flow runs through five named states:

- `ST_IDLE` is the cycle after reset. It always moves to `ST_ALIGN`.
- `ST_ALIGN` waits for a falling serial-clock edge. On that edge it moves to `ST_LOAD`.
- `ST_LOAD` holds the strobe high. On the next falling edge it moves to `ST_SHIFT`.
- `ST_SHIFT` samples one bit on each rising edge. After the sixteenth sample it moves to `ST_COMMIT`.
- `ST_COMMIT` copies the assembled frame to the outputs. It moves back to `ST_ALIGN`.

Top module: `ctlr_ser_rx`

## Requirements
- R1: While `rst_n` is low, `ser_clk`, `ld_strobe`, `frame_tick`, `quad_p0`, `quad_p1` and `misc_bits` are all 0, and `id_word` reads `{8'h00, ID_LOW}`.
- R2: `ser_clk` has a period of 2*DIV_HALF system cycles and is high for exactly DIV_HALF of them.
- R3: `ld_strobe` is high for exactly 2*DIV_HALF system cycles. It rises and falls in the same cycle as a falling edge of `ser_clk`. No bit is sampled while it is high.
- R4: After the strobe falls, the 16 frame bits are sampled from `ser_din` on the next 16 rising edges of `ser_clk`. Received bit k becomes frame bit k (bit 0 is the first received).
- R5: Frame bits 0..3 go to `quad_p0[0..3]`, in this order: port 0 horizontal, horizontal quadrature, vertical, vertical quadrature.
- R6: Frame bits 4..7 go to `quad_p1[0..3]`, with the same phase order as R5 but for port 1.
- R7: Frame bits 8..15 go to `misc_bits[0..7]` and also to `id_word[15:8]`.
- R8: `quad_p0`, `quad_p1`, `misc_bits` and `id_word` change only in the cycle in which `frame_tick` is high. `frame_tick` is high for one cycle per frame.
- R9: Frames repeat continuously. Consecutive `frame_tick` pulses are exactly 17 serial-clock periods (34*DIV_HALF system cycles) apart.
- R10: `id_word[7:0]` always equals the parameter ID_LOW.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ser_din | input | 1 | Serial data from the external converter |
| ser_clk | output | 1 | Generated serial clock; data is sampled on its rising edge |
| ld_strobe | output | 1 | Parallel-load strobe for the external converter |
| quad_p0 | output | 4 | Port 0 quadrature lines: H, HQ, V, VQ in bits 0..3 |
| quad_p1 | output | 4 | Port 1 quadrature lines: H, HQ, V, VQ in bits 0..3 |
| misc_bits | output | 8 | Miscellaneous control byte of the last frame |
| id_word | output | 16 | Identification word: misc byte above, ID_LOW below |
| frame_tick | output | 1 | One-cycle pulse when the outputs take a new frame |

## Verification
Two situations are hard to bring about from the ports. The first is the falling edge that ends the strobe: it must not shift the converter, so the first sampled bit is still frame bit 0. The second is the long shifting stretch in which the outputs must keep the old frame, even though half of the new one is already inside the block. The bench drives a behavioural converter model. The model loads while the strobe is high and shifts only on falling edges that follow a low strobe. The bench then sweeps 512 frames in which the quadrature byte and the misc byte each take all 256 values, so consecutive frames differ in many bits. Any misaligned bit or partial update then shows up either in the frame-end comparison or in the per-cycle hold check.

// File: rtl/ctlr_ser_pkg.sv
package ctlr_ser_pkg;

    localparam int FRAME_BITS = 16;
    localparam int QUAD_BITS  = 4;
    localparam int MISC_BITS  = 8;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_ALIGN  = 3'd1,
        ST_LOAD   = 3'd2,
        ST_SHIFT  = 3'd3,
        ST_COMMIT = 3'd4
    } rx_state_e;

    // First received bit lands in bit 0, so p0 sits at the bottom.
    typedef struct packed {
        logic [MISC_BITS-1:0] misc;
        logic [QUAD_BITS-1:0] p1;
        logic [QUAD_BITS-1:0] p0;
    } frame_t;

endpackage

// File: rtl/ctlr_ser_clkgen.sv
module ctlr_ser_clkgen #(
    parameter int DIV_HALF = 3
) (
    input  logic clk,
    input  logic rst_n,
    output logic sclk,
    output logic rise_evt,
    output logic fall_evt
);
    localparam int CW = (DIV_HALF < 2) ? 1 : $clog2(DIV_HALF);
    localparam logic [CW-1:0] LAST = CW'(DIV_HALF - 1);

    logic [CW-1:0] cnt_q;
    logic          sclk_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            sclk_q <= 1'b0;
        end else if (cnt_q == LAST) begin
            cnt_q  <= '0;
            sclk_q <= ~sclk_q;
        end else begin
            cnt_q  <= cnt_q + 1'b1;
        end
    end

    // Events announce the edge that the next clock tick will produce.
    assign rise_evt = (cnt_q == LAST) && !sclk_q;
    assign fall_evt = (cnt_q == LAST) &&  sclk_q;
    assign sclk     = sclk_q;

    // R2: the serial clock holds its level between divider wraps
    p_sclk_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!rise_evt && !fall_evt) |=> $stable(sclk))
        else $error("serial clock moved without divider event");

endmodule

// File: rtl/ctlr_ser_fsm.sv
module ctlr_ser_fsm
    import ctlr_ser_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      rise_evt,
    input  logic      fall_evt,
    output logic      ld_strobe,
    output logic      sample_en,
    output logic      commit_en,
    output rx_state_e state
);
    localparam int BW = $clog2(FRAME_BITS);
    localparam logic [BW-1:0] LAST_BIT = BW'(FRAME_BITS - 1);

    rx_state_e     state_q, state_nxt;
    logic [BW-1:0] bit_q;
    logic          ld_q;

    always_comb begin
        state_nxt = state_q;
        unique case (state_q)
            ST_IDLE:   state_nxt = ST_ALIGN;
            ST_ALIGN:  if (fall_evt) state_nxt = ST_LOAD;
            ST_LOAD:   if (fall_evt) state_nxt = ST_SHIFT;
            ST_SHIFT:  if (rise_evt && bit_q == LAST_BIT) state_nxt = ST_COMMIT;
            ST_COMMIT: state_nxt = ST_ALIGN;
            default:   state_nxt = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_nxt;
    end

    // Registered outputs: strobe edges coincide with serial clock falls
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ld_q  <= 1'b0;
            bit_q <= '0;
        end else begin
            ld_q <= (state_nxt == ST_LOAD);
            if (state_q == ST_LOAD)  bit_q <= '0;
            else if (sample_en)      bit_q <= bit_q + 1'b1;
        end
    end

    assign sample_en = (state_q == ST_SHIFT) && rise_evt;
    assign commit_en = (state_q == ST_COMMIT);
    assign ld_strobe = ld_q;
    assign state     = state_q;

    // R3: no sampling while the converter is being loaded
    p_no_sample_in_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ld_strobe |-> !sample_en)
        else $error("sample during load strobe");

    // R4: samples only ever happen on rising serial edges
    p_sample_on_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sample_en |-> rise_evt)
        else $error("sample away from rising edge");

    // R9: commit is followed by realignment
    p_commit_then_align_r9: assert property (@(posedge clk) disable iff (!rst_n)
        commit_en |=> (state == ST_ALIGN))
        else $error("commit not followed by align");

endmodule

// File: rtl/ctlr_ser_frame.sv
module ctlr_ser_frame
    import ctlr_ser_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   din,
    input  logic   sample_en,
    input  logic   commit_en,
    output frame_t frame,
    output logic   tick
);
    logic                  din_s;
    logic [FRAME_BITS-1:0] sr_q;
    frame_t                out_q;
    logic                  tick_q;

    generate
        if (SYNC_STAGES == 0) begin : g_nosync
            assign din_s = din;
        end else begin : g_sync
            logic [SYNC_STAGES-1:0] sync_q;
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q[0] <= 1'b0;
                else        sync_q[0] <= din;
            end
            for (genvar g = 1; g < SYNC_STAGES; g++) begin : g_stage
                always_ff @(posedge clk) begin
                    if (!rst_n) sync_q[g] <= 1'b0;
                    else        sync_q[g] <= sync_q[g-1];
                end
            end
            assign din_s = sync_q[SYNC_STAGES-1];
        end
    endgenerate

    // Shift right: after 16 samples the first bit sits in bit 0
    always_ff @(posedge clk) begin
        if (!rst_n)         sr_q <= '0;
        else if (sample_en) sr_q <= {din_s, sr_q[FRAME_BITS-1:1]};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q  <= '0;
            tick_q <= 1'b0;
        end else begin
            tick_q <= commit_en;
            if (commit_en) out_q <= frame_t'(sr_q);
        end
    end

    assign frame = out_q;
    assign tick  = tick_q;

    // R8: frame outputs hold unless a commit was requested
    p_hold_between_commits_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !commit_en |=> $stable(frame))
        else $error("frame output changed without commit");

    // R8: the tick never lasts two cycles
    p_tick_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick)
        else $error("tick longer than one cycle");

endmodule

// File: rtl/ctlr_ser_rx.sv
module ctlr_ser_rx
    import ctlr_ser_pkg::*;
#(
    parameter int          DIV_HALF    = 3,
    parameter int          SYNC_STAGES = 2,
    parameter logic [7:0]  ID_LOW      = 8'hC3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ser_din,
    output logic        ser_clk,
    output logic        ld_strobe,
    output logic [3:0]  quad_p0,
    output logic [3:0]  quad_p1,
    output logic [7:0]  misc_bits,
    output logic [15:0] id_word,
    output logic        frame_tick
);
    // Synchroniser depth must be shorter than half a serial period.
    logic      rise_evt, fall_evt;
    logic      sample_en, commit_en;
    rx_state_e state;
    frame_t    frame;

    ctlr_ser_clkgen #(.DIV_HALF(DIV_HALF)) u_clk (
        .clk      (clk),
        .rst_n    (rst_n),
        .sclk     (ser_clk),
        .rise_evt (rise_evt),
        .fall_evt (fall_evt)
    );

    ctlr_ser_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .rise_evt  (rise_evt),
        .fall_evt  (fall_evt),
        .ld_strobe (ld_strobe),
        .sample_en (sample_en),
        .commit_en (commit_en),
        .state     (state)
    );

    ctlr_ser_frame #(.SYNC_STAGES(SYNC_STAGES)) u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .din       (ser_din),
        .sample_en (sample_en),
        .commit_en (commit_en),
        .frame     (frame),
        .tick      (frame_tick)
    );

    assign quad_p0   = frame.p0;
    assign quad_p1   = frame.p1;
    assign misc_bits = frame.misc;
    assign id_word   = {frame.misc, ID_LOW};

    // R3: strobe starts on a falling serial edge
    p_strobe_rise_on_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ld_strobe) |-> $fell(ser_clk))
        else $error("strobe rose off a falling edge");

    // R3: strobe ends on a falling serial edge
    p_strobe_fall_on_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ld_strobe) |-> $fell(ser_clk))
        else $error("strobe fell off a falling edge");

    // R9: an update follows the last sample by exactly two cycles
    p_tick_after_sample_r9: assert property (@(posedge clk) disable iff (!rst_n)
        frame_tick |-> $past(sample_en, 2))
        else $error("tick without preceding sample");

    // R1: state is idle directly after reset
    p_reset_idle_r1: assert property (@(posedge clk)
        !rst_n |=> (state == ST_IDLE))
        else $error("not idle after reset");

endmodule

// File: tb/sim_ctlr_ser_rx.sv
module sim_ctlr_ser_rx;
    localparam int         DH        = 3;
    localparam logic [7:0] IDL       = 8'hC3;
    localparam int         FRAME_CYC = 34 * DH;
    localparam int         NF        = 512;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_din = 1'b0;
    logic ser_clk, ld_strobe, frame_tick;
    logic [3:0] quad_p0, quad_p1;
    logic [7:0] misc_bits;
    logic [15:0] id_word;

    always #10 clk = ~clk;

    ctlr_ser_rx #(.DIV_HALF(DH), .SYNC_STAGES(2), .ID_LOW(IDL)) u0 (
        .clk(clk), .rst_n(rst_n), .ser_din(ser_din), .ser_clk(ser_clk),
        .ld_strobe(ld_strobe), .quad_p0(quad_p0), .quad_p1(quad_p1),
        .misc_bits(misc_bits), .id_word(id_word), .frame_tick(frame_tick)
    );

    int n_vec = 0;
    int n_bad = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] pat(input int f);
        logic [7:0] a, b;
        if (f < 256) begin a = 8'(f); b = 8'(f * 37 + 11); end
        else         begin b = 8'(f - 256); a = 8'((f - 256) * 91 + 3); end
        return {b, a};
    endfunction

    // converter model and monitors
    logic [15:0] par_in = 16'h0;
    logic [15:0] sreg = 16'h0;
    logic [15:0] latched = 16'h0;
    logic [15:0] exp_q = 16'h0;
    logic prev_sclk = 1'b0, prev_ld = 1'b0, prev_tick = 1'b0;
    int cyc = 0, last_rise = -1, last_tick = -1, ld_len = 0;
    int frames_done = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            cyc++;
            // R2: period and high time
            if (!prev_sclk && ser_clk) begin
                if (last_rise >= 0) chk((cyc - last_rise) == 2 * DH, "R2", 32'(cyc - last_rise), 32'(2 * DH));
                last_rise = cyc;
            end
            if (prev_sclk && !ser_clk && last_rise >= 0)
                chk((cyc - last_rise) == DH, "R2", 32'(cyc - last_rise), 32'(DH));
            // R3: strobe length and edge alignment
            if (ld_strobe) begin
                if (!prev_ld) chk(prev_sclk && !ser_clk, "R3", {30'd0, prev_sclk, ser_clk}, 32'h2);
                ld_len++;
            end else if (prev_ld) begin
                chk(ld_len == 2 * DH, "R3", 32'(ld_len), 32'(2 * DH));
                chk(prev_sclk && !ser_clk, "R3", {30'd0, prev_sclk, ser_clk}, 32'h2);
                ld_len = 0;
            end
            // R8: tick lasts a single cycle
            if (prev_tick) chk(!frame_tick, "R8", {31'd0, frame_tick}, 32'd0);
            if (frame_tick) begin
                // R4 whole-frame alignment, then per-field checks
                chk({misc_bits, quad_p1, quad_p0} == latched, "R4", {misc_bits, quad_p1, quad_p0}, latched);
                chk(quad_p0 == latched[3:0], "R5", quad_p0, latched[3:0]);
                chk(quad_p1 == latched[7:4], "R6", quad_p1, latched[7:4]);
                chk(misc_bits == latched[15:8] && id_word[15:8] == latched[15:8], "R7", id_word, latched);
                chk(id_word[7:0] == IDL, "R10", id_word[7:0], IDL);
                if (last_tick >= 0) chk((cyc - last_tick) == FRAME_CYC, "R9", 32'(cyc - last_tick), 32'(FRAME_CYC));
                last_tick = cyc;
                exp_q = latched;
                frames_done++;
                par_in = pat(frames_done);
            end else begin
                // R8: no change between updates
                chk({misc_bits, quad_p1, quad_p0} == exp_q && id_word == {exp_q[15:8], IDL},
                    "R8", {misc_bits, quad_p1, quad_p0}, exp_q);
            end
            // external converter: load while strobe high, shift on falls after a low strobe
            if (ld_strobe) begin
                sreg = par_in;
                latched = par_in;
            end else if (prev_sclk && !ser_clk && !prev_ld) begin
                sreg = sreg >> 1;
            end
            ser_din = sreg[0];
            prev_sclk = ser_clk;
            prev_ld = ld_strobe;
            prev_tick = frame_tick;
        end
    end

    initial begin
        bit timeout;
        int wd;
        timeout = 1'b0;
        par_in = pat(0);
        repeat (5) @(negedge clk);
        // R1: reset state
        chk(!ser_clk && !ld_strobe && !frame_tick, "R1", {29'd0, ser_clk, ld_strobe, frame_tick}, 32'd0);
        chk(quad_p0 == 4'd0 && quad_p1 == 4'd0 && misc_bits == 8'd0, "R1", {misc_bits, quad_p1, quad_p0}, 32'd0);
        chk(id_word == {8'h00, IDL}, "R1", id_word, {8'h00, IDL});
        rst_n = 1'b1;
        wd = 0;
        while (frames_done < NF && !timeout) begin
            @(negedge clk);
            wd++;
            if (wd > (NF + 2) * FRAME_CYC) timeout = 1'b1;
        end
        if (timeout) chk(1'b0, "watchdog R9", 32'(frames_done), 32'(NF));
        repeat (3) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule